// File: doc/BRIEF.md
# SPI Master Controller

This block is a synchronous serial master for a single slave. A host configures it through three word-wide registers: the clock divider, idle clock level, sampling phase, frame width (8 or 16 bits), bit order and a master enable. It then writes a word to the data register. The block drives the serial clock, the outgoing data line and an active-low select, and it captures the incoming data line into a receive buffer.

There is one buffered word on each side. When the host writes a second word while a frame is on the wire, the controller chains it onto the current frame with no idle clock period. Status flags tell the host when the transmit buffer has room and when a received word is waiting. Two error flags are kept. Overrun means a word arrived while the previous one was still unread. Mode fault means the select-sense input was pulled low while the block was operating as master; the block then drops out of master mode and abandons the transfer.

Top module: `spi_master_ctl`

## Requirements
- R1: Register map, one word per address. Address 0 is control: bits [2:0] divider select, bit 3 idle clock level, bit 4 phase, bit 5 set for 16-bit frames, bit 6 set for LSB-first, bit 7 master enable. Address 1 is data: a write fills the transmit buffer and a read returns the receive buffer. Address 2 is status: bit 0 transmit empty, bit 1 receive full, bit 2 busy, bit 3 overrun, bit 4 mode fault. After reset, control reads 0, status reads 0x0001, select is high and the serial clock is low.
- R2: The serial clock half period is 2^D system cycles, where D is the divider select. Select falls one half period before the first clock edge and rises one half period after the last clock edge. A frame of N bits has 2N clock edges.
- R3: Whenever no frame is active, the serial clock rests at the idle level from control bit 3.
- R4: With phase 0, the first outgoing bit appears when select falls, and both sides sample on the leading edge of each bit. With phase 1, each outgoing bit changes on the leading edge and both sides sample on the trailing edge. A full-duplex exchange completes correctly in all four combinations of idle level and phase.
- R5: Control bit 5 selects a 16-bit frame when set and an 8-bit frame when clear. In 8-bit mode, only the low byte is sent, and the upper byte of a data read returns zero.
- R6: Control bit 6 selects LSB-first order when set and MSB-first order when clear, for both the outgoing and the incoming word.
- R7: A data write clears transmit-empty. Transmit-empty sets again when the controller moves the word into its shifter. Receive-full sets when a received frame completes and clears on a data read.
- R8: If the transmit buffer holds a word when a frame ends, the next frame starts with no gap. Its first edge follows the previous last edge by one half period, and select stays low across both frames.
- R9: A frame that completes while receive-full is still set raises overrun and leaves the receive buffer holding the older word. Overrun clears only on a data read that follows a status read made while overrun was set.
- R10: When master is enabled and the select-sense input is low, the controller sets mode fault, clears the master-enable bit, raises select and returns the clock to idle within 4 cycles. No transfer starts until control is written again, and that write clears mode fault.
- R11: Control writes made while busy is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-style reset, sampled on clk |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (data and status reads have side effects) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from host_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |
| ss_in_n | input | 1 | Select-sense input; low while master is enabled is a mode fault |

## Verification
Register strobes take effect at the next rising edge, and read data is combinational. The bench therefore drives a strobe at a falling edge, samples read data 1 ns later, and sees flag changes at the next falling edge. A control or data write is followed by one more cycle before the transfer begins: select falls two edges after the data write, and transmit-empty is observed clear in the cycle between those two edges. Serial timing is measured in nanoseconds between select and clock transitions and compared with multiples of 4 ns times 2^D. A mode fault is checked after 4 cycles, which covers the 2-stage synchronizer and the registered abort.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;

  localparam int WORD_W   = 16;
  localparam int NARROW_W = 8;
  localparam int DIV_W    = 3;
  localparam int EDGE_W   = $clog2(2 * WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_TRAIL
  } eng_state_t;

  typedef struct packed {
    logic             lsb_first;
    logic             wide;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div_sel;
  } frame_cfg_t;

  // Place the outgoing bits so that the next bit to send is always the top bit.
  function automatic logic [WORD_W-1:0] align_tx(input logic [WORD_W-1:0] w,
                                                 input logic wide,
                                                 input logic lsb);
    logic [WORD_W-1:0] r;
    r = '0;
    if (wide) begin
      for (int i = 0; i < WORD_W; i++)
        r[WORD_W-1-i] = lsb ? w[i] : w[WORD_W-1-i];
    end else begin
      for (int i = 0; i < NARROW_W; i++)
        r[WORD_W-1-i] = lsb ? w[i] : w[NARROW_W-1-i];
    end
    return r;
  endfunction

  // The shift history holds the first received bit at position n-1.
  function automatic logic [WORD_W-1:0] collect_rx(input logic [WORD_W-1:0] sh,
                                                   input logic wide,
                                                   input logic lsb);
    logic [WORD_W-1:0] r;
    int n;
    r = '0;
    n = wide ? WORD_W : NARROW_W;
    for (int i = 0; i < WORD_W; i++)
      if (i < n) r[i] = lsb ? sh[n-1-i] : sh[i];
    return r;
  endfunction

  function automatic logic [EDGE_W-1:0] last_edge_of(input logic wide);
    return wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * NARROW_W - 1);
  endfunction

endpackage

// File: rtl/spi_mc_prescaler.sv
module spi_mc_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);

  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || cnt == limit) cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/spi_mc_engine.sv
module spi_mc_engine
  import spi_mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              abort,
  input  frame_cfg_t        cfg,
  input  logic              tx_avail,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              tx_take,
  output logic              frame_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n
);

  eng_state_t        state;
  logic [EDGE_W-1:0] edge_idx;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_next, prep, load_sh;
  logic              sclk_q, mosi_q, ss_q, load_mosi;
  logic              tick, active, at_last, sample_now, drive_now;
  logic              start_idle, chain;

  spi_mc_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state != ST_IDLE),
    .div_sel(cfg.div_sel),
    .tick   (tick)
  );

  assign active     = (state == ST_ACTIVE) && tick;
  assign at_last    = (edge_idx == last_edge_of(cfg.wide));
  assign sample_now = active && (edge_idx[0] == cfg.cpha);
  assign drive_now  = active && (edge_idx[0] != cfg.cpha) && !at_last;
  assign frame_done = active && at_last;
  assign start_idle = (state == ST_IDLE) && enable && tx_avail && !abort;
  assign chain      = frame_done && enable && tx_avail && !abort;
  assign tx_take    = start_idle || chain;

  assign prep      = align_tx(tx_word, cfg.wide, cfg.lsb_first);
  assign load_sh   = cfg.cpha ? prep : (prep << 1);
  assign load_mosi = cfg.cpha ? mosi_q : prep[WORD_W-1];

  assign rx_next = sample_now ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
  assign rx_word = collect_rx(rx_next, cfg.wide, cfg.lsb_first);

  assign busy = (state != ST_IDLE);
  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign ss_n = ss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sh <= '0;
    else        rx_sh <= rx_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_idx <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      ss_q     <= 1'b1;
      tx_sh    <= '0;
    end else if (abort) begin
      state    <= ST_IDLE;
      edge_idx <= '0;
      sclk_q   <= cfg.cpol;
      ss_q     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sclk_q <= cfg.cpol;
          if (start_idle) begin
            state    <= ST_ACTIVE;
            ss_q     <= 1'b0;
            edge_idx <= '0;
            tx_sh    <= load_sh;
            mosi_q   <= load_mosi;
          end
        end
        ST_ACTIVE: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (drive_now) begin
              mosi_q <= tx_sh[WORD_W-1];
              tx_sh  <= tx_sh << 1;
            end
            if (at_last) begin
              edge_idx <= '0;
              if (chain) begin
                tx_sh  <= load_sh;
                mosi_q <= load_mosi;
              end else begin
                state <= ST_TRAIL;
              end
            end else begin
              edge_idx <= edge_idx + EDGE_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            ss_q  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_mc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  input  logic              ss_in_n
);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(2);
  localparam int CFG_W = $bits(frame_cfg_t);

  frame_cfg_t        cfg_q;
  logic              master_en, modf, txe, rxne, ovr, ovr_armed;
  logic [WORD_W-1:0] tx_buf, rx_buf, rx_word;
  logic              sense_s1, sense_s2;

  // Named internal events.
  logic ctrl_wr, data_wr, data_rd, stat_rd;
  logic modf_event, ovr_event, tx_take, frame_done, eng_busy;

  assign ctrl_wr    = host_wr && (host_addr == ADDR_CTRL) && !eng_busy;
  assign data_wr    = host_wr && (host_addr == ADDR_DATA);
  assign data_rd    = host_rd && (host_addr == ADDR_DATA);
  assign stat_rd    = host_rd && (host_addr == ADDR_STAT);
  assign modf_event = master_en && !sense_s2;
  assign ovr_event  = frame_done && rxne;

  spi_mc_engine engine_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (master_en && !modf),
    .abort     (modf_event),
    .cfg       (cfg_q),
    .tx_avail  (!txe),
    .tx_word   (tx_buf),
    .miso      (miso),
    .tx_take   (tx_take),
    .frame_done(frame_done),
    .rx_word   (rx_word),
    .busy      (eng_busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .ss_n      (ss_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_s1 <= 1'b1;
      sense_s2 <= 1'b1;
    end else begin
      sense_s1 <= ss_in_n;
      sense_s2 <= sense_s1;
    end
  end

  // Control register and mode fault.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      master_en <= 1'b0;
      modf      <= 1'b0;
    end else if (modf_event) begin
      master_en <= 1'b0;
      modf      <= 1'b1;
    end else if (ctrl_wr) begin
      cfg_q     <= frame_cfg_t'(host_wdata[CFG_W-1:0]);
      master_en <= host_wdata[CFG_W];
      modf      <= 1'b0;
    end
  end

  // Transmit buffer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf <= '0;
      txe    <= 1'b1;
    end else if (data_wr) begin
      tx_buf <= host_wdata;
      txe    <= 1'b0;
    end else if (tx_take) begin
      txe <= 1'b1;
    end
  end

  // Receive buffer and overrun.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf    <= '0;
      rxne      <= 1'b0;
      ovr       <= 1'b0;
      ovr_armed <= 1'b0;
    end else begin
      if (frame_done && !rxne) begin
        rx_buf <= rx_word;
        rxne   <= 1'b1;
      end else if (data_rd) begin
        rxne <= 1'b0;
      end
      if (ovr_event) begin
        ovr       <= 1'b1;
        ovr_armed <= 1'b0;
      end else if (stat_rd && ovr) begin
        ovr_armed <= 1'b1;
      end else if (data_rd) begin
        if (ovr_armed) ovr <= 1'b0;
        ovr_armed <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      ADDR_CTRL: host_rdata[CFG_W:0] = {master_en, cfg_q};
      ADDR_DATA: host_rdata = rx_buf;
      ADDR_STAT: host_rdata[4:0] = {modf, ovr, eng_busy, rxne, txe};
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_master_ctl_chk.sv
module spi_master_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sclk,
  input logic ss_n,
  input logic cpol,
  input logic tx_take,
  input logic data_wr,
  input logic txe,
  input logic frame_done,
  input logic rxne,
  input logic ovr,
  input logic modf_event,
  input logic modf,
  input logic master_en
);

  // R3: settled idle clock rests at the configured level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sclk == cpol));

  // R2: select low exactly while a frame (including its trailing half period) runs
  a_r2_select_span: assert property (@(posedge clk) disable iff (!rst_n)
    busy != ss_n);

  // R7: word moved into the shifter frees the buffer
  a_r7_txe_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !data_wr) |=> txe);

  // R7: a data write fills the buffer
  a_r7_txe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !txe);

  // R7: receive-full only rises from a completed frame
  a_r7_rxne_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> $past(frame_done));

  // R9: completion onto an unread word raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rxne) |=> ovr);

  // R10: mode fault drops master mode and releases select
  a_r10_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    modf_event |=> (ss_n && !master_en && modf));

endmodule

bind spi_master_ctl spi_master_ctl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (eng_busy),
  .sclk      (sclk),
  .ss_n      (ss_n),
  .cpol      (cfg_q.cpol),
  .tx_take   (tx_take),
  .data_wr   (data_wr),
  .txe       (txe),
  .frame_done(frame_done),
  .rxne      (rxne),
  .ovr       (ovr),
  .modf_event(modf_event),
  .modf      (modf),
  .master_en (master_en)
);

// File: tb/spi_master_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_master_ctl_tb_top;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        sclk, mosi, ss_n;
  logic        miso = 1'b0;
  logic        ss_in_n = 1'b1;

  int n_checks = 0, n_errs = 0;
  bit done = 1'b0;

  spi_master_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .ss_in_n(ss_in_n)
  );

  always #(CLK_NS/2) clk = ~clk;

  // ---------------- slave model and timing probes ----------------
  bit          b_cpol, b_cpha, b_wide, b_lsb;
  logic [15:0] sl_words [0:3];
  logic [15:0] cap_words [0:3];
  logic        cap_bits [0:15];
  int          sl_out_i, sl_out_f, sl_in_i, sl_in_f;
  int          edge_cnt;
  longint      t_first, t_last, t_fall, t_rise;

  function automatic logic pick_bit(logic [15:0] w, int idx, bit wide, bit lsb);
    int n;
    n = wide ? 16 : 8;
    return lsb ? w[idx] : w[n-1-idx];
  endfunction

  task automatic slave_drive();
    int n;
    n = b_wide ? 16 : 8;
    if (sl_out_i >= n) begin
      sl_out_i = 0;
      sl_out_f++;
    end
    miso = pick_bit(sl_words[sl_out_f & 3], sl_out_i, b_wide, b_lsb);
    sl_out_i++;
  endtask

  task automatic slave_sample();
    int n;
    logic [15:0] w;
    n = b_wide ? 16 : 8;
    cap_bits[sl_in_i] = mosi;
    sl_in_i++;
    if (sl_in_i == n) begin
      w = '0;
      for (int i = 0; i < n; i++)
        if (b_lsb) w[i] = cap_bits[i]; else w[n-1-i] = cap_bits[i];
      cap_words[sl_in_f & 3] = w;
      sl_in_f++;
      sl_in_i = 0;
    end
  endtask

  always @(negedge ss_n) begin
    t_fall   = $time;
    sl_out_i = 0; sl_out_f = 0; sl_in_i = 0; sl_in_f = 0;
    if (!b_cpha) begin
      #1 slave_drive();
    end
  end

  always @(posedge ss_n) t_rise = $time;

  always @(sclk) begin
    edge_cnt++;
    if (edge_cnt == 1) t_first = $time;
    t_last = $time;
    if (!ss_n) begin
      #1;
      if ((sclk != b_cpol) == !b_cpha) slave_sample();
      else                             slave_drive();
    end
  end

  // ---------------- host tasks (called at a falling edge) ----------------
  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_frame_end();
    repeat (2) @(negedge clk);
    while (!ss_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrl_word(bit en, bit lsb, bit wide, bit cpha,
                                            bit cpol, int div);
    return {8'h00, en, lsb, wide, cpha, cpol, 3'(div)};
  endfunction

  function automatic logic [15:0] narrow(logic [15:0] w, bit wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] d;
    host_read(2'd0, d); check("R1 control after reset", d, 16'h0000);
    host_read(2'd2, d); check("R1 status after reset", d, 16'h0001);
    check("R1 select idle", ss_n, 1);
    check("R1 clock idle", sclk, 0);
  endtask

  task automatic t_exchange(input string tag, input bit cpol, input bit cpha,
                            input bit wide, input bit lsb, input int div,
                            input logic [15:0] mword, input logic [15:0] sword);
    logic [15:0] d;
    int n, half;
    n = wide ? 16 : 8;
    half = 1 << div;
    b_cpol = cpol; b_cpha = cpha; b_wide = wide; b_lsb = lsb;
    sl_words[0] = sword;
    host_write(2'd0, ctrl_word(1, lsb, wide, cpha, cpol, div));
    repeat (2) @(negedge clk);
    check({tag, " R3 idle level"}, sclk, cpol);
    edge_cnt = 0;
    host_write(2'd1, mword);
    host_read(2'd2, d);
    check({tag, " R7 txe clears on write"}, d[0], 0);
    wait_frame_end();
    check({tag, " R2 edge count"}, edge_cnt, 2 * n);
    check({tag, " R2 lead time"}, t_first - t_fall, half * CLK_NS);
    check({tag, " R2 bit spacing"}, t_last - t_first, (2 * n - 1) * half * CLK_NS);
    check({tag, " R2 trail time"}, t_rise - t_last, half * CLK_NS);
    check({tag, " R3 idle after frame"}, sclk, cpol);
    check({tag, " R4 slave got word"}, cap_words[0], narrow(mword, wide));
    host_read(2'd2, d);
    check({tag, " R7 status after frame"}, d, 16'h0003);
    host_read(2'd1, d);
    check({tag, " R5 R6 received word"}, d, narrow(sword, wide));
    host_read(2'd2, d);
    check({tag, " R7 rxne clears on read"}, d, 16'h0001);
  endtask

  task automatic t_chain();
    logic [15:0] d;
    b_cpol = 0; b_cpha = 0; b_wide = 0; b_lsb = 0;
    sl_words[0] = 16'h00C3; sl_words[1] = 16'h005A;
    host_write(2'd0, ctrl_word(1, 0, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    edge_cnt = 0;
    host_write(2'd1, 16'h0091);
    d = 16'h0000;
    while (d[0] == 1'b0) host_read(2'd2, d);
    host_write(2'd1, 16'h006E);
    wait_frame_end();
    check("R8 chained edge count", edge_cnt, 32);
    check("R8 no gap between frames", t_last - t_first, 31 * 2 * CLK_NS);
    check("R8 first chained word", cap_words[0], 16'h0091);
    check("R8 second chained word", cap_words[1], 16'h006E);
    host_read(2'd1, d);
    check("R9 old word kept", d, 16'h00C3);
    host_read(2'd2, d);
    check("R9 overrun survives data-only read", d, 16'h0009);
    host_read(2'd1, d);
    host_read(2'd2, d);
    check("R9 overrun cleared by status then data read", d, 16'h0001);
  endtask

  task automatic t_busy_ctrl();
    logic [15:0] d;
    logic [15:0] cw;
    b_cpol = 1; b_cpha = 0; b_wide = 1; b_lsb = 0;
    sl_words[0] = 16'h1357;
    cw = ctrl_word(1, 0, 1, 0, 1, 3);
    host_write(2'd0, cw);
    repeat (2) @(negedge clk);
    host_write(2'd1, 16'hC0DE);
    repeat (10) @(negedge clk);
    host_write(2'd0, 16'h0000);
    host_read(2'd0, d);
    check("R11 control write ignored while busy", d, cw);
    wait_frame_end();
    check("R11 frame unaffected", cap_words[0], 16'hC0DE);
    host_read(2'd1, d);
    check("R11 received word", d, 16'h1357);
  endtask

  task automatic t_fault();
    logic [15:0] d;
    b_cpol = 0; b_cpha = 1; b_wide = 1; b_lsb = 1;
    host_write(2'd0, ctrl_word(1, 1, 1, 1, 0, 3));
    repeat (2) @(negedge clk);
    host_write(2'd1, 16'hAAAA);
    repeat (20) @(negedge clk);
    check("R10 transfer under way", ss_n, 0);
    ss_in_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 select released", ss_n, 1);
    check("R10 clock idle", sclk, 0);
    host_read(2'd2, d);
    check("R10 fault flag", d[4], 1);
    host_read(2'd0, d);
    check("R10 master enable cleared", d[7], 0);
    ss_in_n = 1'b1;
    host_write(2'd1, 16'h5555);
    repeat (20) @(negedge clk);
    check("R10 no transfer while faulted", ss_n, 1);
    host_write(2'd0, ctrl_word(1, 1, 1, 1, 0, 0));
    host_read(2'd2, d);
    check("R10 control write clears fault", d[4], 0);
    wait_frame_end();
    check("R10 transfer resumes", cap_words[0], 16'h5555);
    host_read(2'd1, d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exchange("mode00", 0, 0, 0, 0, 0, 16'h00A5, 16'h003C);
    t_exchange("mode01", 0, 1, 1, 0, 2, 16'h1234, 16'hBEEF);
    t_exchange("mode10", 1, 0, 0, 1, 3, 16'h0013, 16'hFF81);
    t_exchange("mode11", 1, 1, 1, 1, 1, 16'hF00D, 16'h8421);
    t_chain();
    t_busy_ctrl();
    t_fault();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule